// File: doc/BRIEF.md
# Framed Word Serializer with Sync Mode

The block is the transmit end of a serial link. It runs on the bit clock. Once every frame period it takes one parallel data word, adds a fixed frame around it, and shifts out one bit per clock. The frame puts a high marker bit in front of the word and a low marker bit after it, so the line rises at every frame boundary. A receiver can recover the word clock from that edge.

There are two sync-request inputs. While either one is high at a frame boundary, the frame slot carries a fixed alignment pattern instead of data: ones for the first half of the slot and zeros for the second half. A receiver's active-high loss-of-lock output can be tied straight to one of these inputs. The serializer then keeps sending alignment frames until the receiver reports lock.

A load strobe marks the cycle in which the word and the sync requests are captured. Upstream logic presents each new word in that cycle. Inputs are read only at that edge, so a frame is never cut short or mixed.

Top module: `frame_serializer`

## Requirements
- R1: While reset is asserted, and after release until the first frame starts, `ser_o` is held at 1 (idle).
- R2: `load_o` is high in the first cycle after reset release and then exactly once every DATA_W+2 cycles. It is low in every other cycle.
- R3: In the cycle after a `load_o` cycle, `ser_o` carries the start bit, which is 1.
- R4: In the next DATA_W cycles, `ser_o` carries data bits 0 up to DATA_W-1 of the captured word, least significant bit first.
- R5: The last bit of each frame is the end bit, 0. It appears in the cycle of the next `load_o`, so `ser_o` rises from 0 to 1 at every frame boundary.
- R6: A sync frame is (DATA_W+2)/2 ones followed by (DATA_W+2)/2 zeros, in place of the framed data. With the default width this is six ones then six zeros.
- R7: A sync frame is sent when `sync_a_i`, `sync_b_i`, or both are high at the load edge. The word on `word_i` is then ignored.
- R8: `word_i`, `sync_a_i` and `sync_b_i` are sampled only at the clock edge that ends a `load_o` cycle. Changes at any other time do not alter the frame in flight.
- R9: While a sync request stays high across boundaries, every frame is a sync frame. The first boundary that sees the request low starts a data frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_i | input | DATA_W | Parallel word, captured at the load edge |
| sync_a_i | input | 1 | Sync request A, active high |
| sync_b_i | input | 1 | Sync request B (for example, the receiver's loss-of-lock), active high |
| ser_o | output | 1 | Serial line output |
| load_o | output | 1 | Load strobe, high in the cycle whose closing edge captures the inputs |

## Verification
Two things can happen in the same cycle: the end bit of one frame goes out while the next frame's contents are captured. A sync request also changes meaning depending on whether it arrives on that cycle or inside a frame. The bench runs frames back to back, so every boundary cycle checks the outgoing end bit and the new capture together. It also drives sync requests and new words in the middle of a frame and then checks that the frame in flight and the next frame carry exactly the values present at the boundary edge. Sync frames held for several periods, followed by a release, show that data returns at the first boundary after the release.

// File: rtl/frame_ser_pkg.sv
package frame_ser_pkg;
  typedef enum logic {
    KIND_DATA = 1'b0,
    KIND_SYNC = 1'b1
  } frame_kind_e;
endpackage

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int FRAME_LEN = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o
);
  localparam int CW = $clog2(FRAME_LEN);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           cnt_q <= '0;
    else if (cnt_q == CW'(FRAME_LEN - 1))  cnt_q <= '0;
    else                                   cnt_q <= cnt_q + CW'(1);
  end

  assign load_o = (cnt_q == '0);
endmodule

// File: rtl/frame_builder.sv
module frame_builder
  import frame_ser_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic [DATA_W-1:0]   word_i,
  input  frame_kind_e         kind_i,
  output logic [DATA_W+1:0]   frame_o
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int HALF      = FRAME_LEN / 2;

  logic [FRAME_LEN-1:0] sync_pat;
  logic [FRAME_LEN-1:0] data_pat;

  // alignment pattern: ones in the first half of the slot, LSB leaves first
  for (genvar i = 0; i < FRAME_LEN; i++) begin : g_sync
    assign sync_pat[i] = (i < HALF);
  end

  assign data_pat = {1'b0, word_i, 1'b1};

  always_comb begin
    unique case (kind_i)
      KIND_SYNC: frame_o = sync_pat;
      default:   frame_o = data_pat;
    endcase
  end
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
  parameter int FRAME_LEN = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 load_i,
  input  logic [FRAME_LEN-1:0] frame_i,
  output logic                 ser_o
);
  logic [FRAME_LEN-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '1;
    else if (load_i) sh_q <= frame_i;
    else             sh_q <= {1'b1, sh_q[FRAME_LEN-1:1]};
  end

  assign ser_o = sh_q[0];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import frame_ser_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sync_a_i,
  input  logic              sync_b_i,
  output logic              ser_o,
  output logic              load_o
);
  localparam int FRAME_LEN = DATA_W + 2;

  logic                 load;
  logic [FRAME_LEN-1:0] frame;
  frame_kind_e          kind;

  assign kind   = (sync_a_i || sync_b_i) ? KIND_SYNC : KIND_DATA;
  assign load_o = load;

  slot_counter #(.FRAME_LEN(FRAME_LEN)) i_slot_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_o (load)
  );

  frame_builder #(.DATA_W(DATA_W)) i_frame_builder (
    .word_i  (word_i),
    .kind_i  (kind),
    .frame_o (frame)
  );

  frame_shifter #(.FRAME_LEN(FRAME_LEN)) i_frame_shifter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .frame_i (frame),
    .ser_o   (ser_o)
  );
endmodule

// File: rtl/frame_serializer_chk.sv
module frame_serializer_chk #(
  parameter int DATA_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] word_i,
  input logic              sync_a_i,
  input logic              sync_b_i,
  input logic              ser_o,
  input logic              load_o
);
  localparam int FRAME_LEN = DATA_W + 2;
  localparam int HALF      = FRAME_LEN / 2;
  localparam int PW        = $clog2(FRAME_LEN + 1);

  logic          seen_q;
  logic          sync_q;
  logic [PW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      sync_q <= 1'b0;
      pos_q  <= '0;
    end else begin
      seen_q <= seen_q | load_o;
      if (load_o) begin
        sync_q <= sync_a_i | sync_b_i;
        pos_q  <= PW'(1);
      end else if (seen_q && pos_q != PW'(FRAME_LEN)) begin
        pos_q  <= pos_q + PW'(1);
      end
    end
  end

  a_r1_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> ser_o);
  a_r2_load_on_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && load_o) |-> (pos_q == PW'(FRAME_LEN)));
  a_r2_period_has_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q == PW'(FRAME_LEN)) |-> load_o);
  a_r3_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> ser_o);
  a_r5_end_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && load_o) |-> !ser_o);
  a_r5_boundary_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && load_o) |=> $rose(ser_o));
  a_r6_sync_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && pos_q >= PW'(1) && pos_q <= PW'(HALF)) |-> ser_o);
  a_r6_sync_zeros: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && pos_q > PW'(HALF)) |-> !ser_o);
endmodule

bind frame_serializer frame_serializer_chk #(.DATA_W(DATA_W)) i_frame_serializer_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .word_i   (word_i),
  .sync_a_i (sync_a_i),
  .sync_b_i (sync_b_i),
  .ser_o    (ser_o),
  .load_o   (load_o)
);

// File: tb/test_frame_serializer.sv
module test_frame_serializer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 10;
  localparam int FRAME_LEN  = DATA_W + 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DATA_W-1:0] word = '0;
  logic              sync_a = 1'b0;
  logic              sync_b = 1'b0;
  logic              ser;
  logic              load;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_serializer #(.DATA_W(DATA_W)) i_frame_serializer (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .word_i   (word),
    .sync_a_i (sync_a),
    .sync_b_i (sync_b),
    .ser_o    (ser),
    .load_o   (load)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic [FRAME_LEN-1:0] expect_frame(input logic [DATA_W-1:0] w, input bit s);
    logic [FRAME_LEN-1:0] f;
    if (s) for (int i = 0; i < FRAME_LEN; i++) f[i] = (i < FRAME_LEN/2);
    else   f = {1'b0, w, 1'b1};
    return f;
  endfunction

  // Called at a negedge where load is high; drives inputs, checks the whole frame,
  // returns at the negedge of the next load cycle. scramble changes inputs mid-frame (R8).
  task automatic send_frame(input logic [DATA_W-1:0] w, input bit sa, input bit sb,
                            input bit scramble, input string tag);
    logic [FRAME_LEN-1:0] exp;
    string req;
    check("R2", {tag, " load at boundary"}, load, 1'b1);
    word = w; sync_a = sa; sync_b = sb;
    exp = expect_frame(w, sa | sb);
    for (int i = 0; i < FRAME_LEN; i++) begin
      @(negedge clk);
      if (scramble && i == 3) begin
        word = ~w; sync_a = ~sa; sync_b = ~sb;
      end
      if (sa | sb)                req = "R6";
      else if (i == 0)            req = "R3";
      else if (i == FRAME_LEN-1)  req = "R5";
      else                        req = "R4";
      if (scramble) req = {req, "/R8"};
      check(req, $sformatf("%s bit %0d", tag, i), ser, exp[i]);
      check("R2", $sformatf("%s load slot %0d", tag, i), load, logic'(i == FRAME_LEN-1));
    end
  endtask

  task automatic t_reset;
    #(CLK_PERIOD*2 + 1);
    check("R1", "ser in reset", ser, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1", "ser idle after release", ser, 1'b1);
    check("R2", "first load after release", load, 1'b1);
  endtask

  task automatic t_data;
    send_frame(10'h3FF, 1'b0, 1'b0, 1'b0, "data_all_ones");
    send_frame(10'h000, 1'b0, 1'b0, 1'b0, "data_all_zeros");
    send_frame(10'h2A5, 1'b0, 1'b0, 1'b0, "data_mixed");
    send_frame(10'h155, 1'b0, 1'b0, 1'b0, "data_alt");
    send_frame(10'h001, 1'b0, 1'b0, 1'b0, "data_lsb_only");
    send_frame(10'h200, 1'b0, 1'b0, 1'b0, "data_msb_only");
  endtask

  task automatic t_sync_inputs;
    send_frame(10'h0F0, 1'b1, 1'b0, 1'b0, "R7_sync_a");
    send_frame(10'h30F, 1'b0, 1'b1, 1'b0, "R7_sync_b");
    send_frame(10'h3FF, 1'b1, 1'b1, 1'b0, "R7_sync_both");
  endtask

  task automatic t_mid_frame;
    send_frame(10'h1C3, 1'b0, 1'b0, 1'b1, "R8_data_scrambled");
    send_frame(10'h2A5, 1'b1, 1'b0, 1'b1, "R8_sync_scrambled");
  endtask

  task automatic t_sync_hold;
    for (int k = 0; k < 4; k++) send_frame(10'h3C3, 1'b0, 1'b1, 1'b0, "R9_lock_lost");
    send_frame(10'h19B, 1'b0, 1'b0, 1'b0, "R9_resumed");
  endtask

  initial begin
    t_reset();
    t_data();
    t_sync_inputs();
    t_mid_frame();
    t_sync_hold();
    send_frame(10'h000, 1'b0, 1'b0, 1'b0, "R5_final");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule